// File: doc/BRIEF.md
# Processor status register bank with exception save

This block holds the live processor status word of a 32-bit core together with five saved copies, one for each exception mode (fast interrupt, interrupt, supervisor, abort, undefined). The live word carries the four condition flags (negative, zero, carry, overflow), the two interrupt masks, the instruction-state bit and a five-bit mode code. The execute stage offers ALU results every cycle, and the flags take them only when the instruction's set-flags bit is raised. Arithmetic and logical operations source the carry and overflow flags differently.

On exception entry the live word is copied into the saved copy that belongs to the mode being entered. In the same clock edge the mode switches, the interrupt masks are raised and the state bit is cleared. On exception return the live word is reloaded from the saved copy of the current mode. Software-style direct reads and writes reach either the live word or the current mode's saved copy. Privilege limits what those accesses may change.

Top module: `psr_bank`

## Requirements
- R1: After reset the live word reads 0x000000D3: supervisor mode, I=1, F=1, T=0, all flags clear. Every saved copy reads 0x00000010.
- R2: The word layout is N bit 31, Z bit 30, C bit 29, V bit 28, I bit 7, F bit 6, T bit 5, mode bits 4:0. Bits 27:8 always read zero. The mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. `rd_saved`=0 returns the live word on `rd_data` and `rd_saved`=1 returns the current mode's saved copy. Both reads are combinational.
- R3: When `set_flags` is low and no other request is present, N, Z, C and V hold their values.
- R4: With `set_flags` high and `alu_logic` low, the flags are updated on the clock edge. N takes result bit 31, Z is set when the result is zero, C takes `alu_cout` and V takes `alu_ovf`.
- R5: With `set_flags` high and `alu_logic` high, N and Z follow the result as in R4, C takes `shift_cout` and V keeps its value.
- R6: `exc_req` with `exc_kind` 0 (reset) enters supervisor mode. Kind 1 enters undefined, 2 supervisor, 3 abort, 4 interrupt and 5 fast interrupt. On that edge the old live word is stored in the target mode's saved copy, I becomes 1, T becomes 0 and the mode becomes the target code. F becomes 1 for kinds 0 and 5 and holds for the other kinds. The flags keep their values. Kinds 6 and 7 have no effect.
- R7: `exc_ret` in a mode that owns a saved copy replaces the whole live word with that copy, including T.
- R8: In user or system mode, `exc_ret` has no effect, a saved-copy read returns zero, and a saved-copy write changes nothing.
- R9: A live-word write (`wr_en`=1, `wr_saved`=0) in user mode changes only N, Z, C and V.
- R10: A live-word write in a privileged mode changes the flags, I and F. It changes the mode only when the written code is one of the seven valid codes. T is never changed by it.
- R11: A saved-copy write (`wr_en`=1, `wr_saved`=1) in a privileged mode stores N, Z, C, V, I, F, T and the mode code into the current mode's copy. Reserved bits are stored as zero, and an invalid mode code leaves the stored mode as it was.
- R12: When several requests arrive on the same edge, priority runs exception entry, then return, then live-word write, then flag update. A lower-priority live-word change in that cycle is discarded. A saved-copy write is dropped when an exception or a return is taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| set_flags | input | 1 | Instruction's set-flags bit |
| alu_logic | input | 1 | 1 = logical operation, 0 = arithmetic |
| alu_res | input | 32 | ALU result |
| alu_cout | input | 1 | Carry out of bit 31 (arithmetic) |
| alu_ovf | input | 1 | Signed overflow (arithmetic) |
| shift_cout | input | 1 | Shifter carry-out (logical) |
| exc_req | input | 1 | Exception entry request |
| exc_kind | input | 3 | Exception kind, encoding per R6 |
| exc_ret | input | 1 | Exception return request |
| wr_en | input | 1 | Direct write strobe |
| wr_saved | input | 1 | 0 = write live word, 1 = write current saved copy |
| wr_data | input | 32 | Direct write data |
| rd_saved | input | 1 | 0 = read live word, 1 = read current saved copy |
| rd_data | output | 32 | Direct read data |
| psr_out | output | 32 | Live status word |

## Verification
Exception entry and a flag update can share an edge, as can a return and a flag update. The bench provokes both by raising `set_flags` with a zero result and a carry in the same cycle as `exc_req` or `exc_ret`. It then judges the live word, which must carry the pre-exception flags or the restored copy untouched by the ALU values, and the saved copy, which must hold the word as it stood before the edge. A saved-copy write issued together with a return is checked the same way: the copy read afterwards must still hold the old contents.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int WORD_W    = 32;
  localparam int MODE_W    = 5;
  localparam int NUM_SAVED = 5;
  localparam int IDX_W     = $clog2(NUM_SAVED);
  localparam int KIND_W    = 3;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  typedef struct packed {
    logic              n;
    logic              z;
    logic              c;
    logic              v;
    logic [19:0]       rsvd;
    logic              i;
    logic              f;
    logic              t;
    logic [MODE_W-1:0] mode;
  } psr_t;

  localparam psr_t PSR_RESET   = '{n:1'b0, z:1'b0, c:1'b0, v:1'b0, rsvd:'0,
                                   i:1'b1, f:1'b1, t:1'b0, mode:MODE_SVC};
  localparam psr_t SAVED_RESET = '{n:1'b0, z:1'b0, c:1'b0, v:1'b0, rsvd:'0,
                                   i:1'b0, f:1'b0, t:1'b0, mode:MODE_USR};

  function automatic logic mode_valid(input logic [MODE_W-1:0] m);
    return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) ||
           (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
           (m == MODE_SYS);
  endfunction

  function automatic logic [MODE_W-1:0] slot_mode(input int idx);
    case (idx)
      0:       return MODE_FIQ;
      1:       return MODE_IRQ;
      2:       return MODE_SVC;
      3:       return MODE_ABT;
      default: return MODE_UND;
    endcase
  endfunction

  function automatic logic has_slot(input logic [MODE_W-1:0] m);
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NUM_SAVED; k++) hit |= (m == slot_mode(k));
    return hit;
  endfunction

  function automatic logic [IDX_W-1:0] slot_idx(input logic [MODE_W-1:0] m);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int k = 0; k < NUM_SAVED; k++)
      if (m == slot_mode(k)) idx = IDX_W'(k);
    return idx;
  endfunction

  function automatic logic kind_valid(input logic [KIND_W-1:0] k);
    return k <= 3'd5;
  endfunction

  function automatic logic [MODE_W-1:0] kind_mode(input logic [KIND_W-1:0] k);
    case (k)
      3'd1:    return MODE_UND;
      3'd3:    return MODE_ABT;
      3'd4:    return MODE_IRQ;
      3'd5:    return MODE_FIQ;
      default: return MODE_SVC;
    endcase
  endfunction

  function automatic logic kind_masks_fast(input logic [KIND_W-1:0] k);
    return (k == 3'd0) || (k == 3'd5);
  endfunction

  // Returns {N,Z,C,V} for one ALU result.
  function automatic logic [3:0] calc_nzcv(input logic              logical,
                                           input logic [WORD_W-1:0] res,
                                           input logic              cout,
                                           input logic              ovf,
                                           input logic              sh_c,
                                           input logic              old_v);
    logic n_f, z_f, c_f, v_f;
    n_f = res[WORD_W-1];
    z_f = (res == '0);
    c_f = logical ? sh_c  : cout;
    v_f = logical ? old_v : ovf;
    return {n_f, z_f, c_f, v_f};
  endfunction

endpackage

// File: rtl/psr_flag_unit.sv
module psr_flag_unit
  import psr_pkg::*;
(
  input  logic              logical,
  input  logic [WORD_W-1:0] res,
  input  logic              cout,
  input  logic              ovf,
  input  logic              sh_c,
  input  logic              old_v,
  output logic [3:0]        nzcv
);

  assign nzcv = calc_nzcv(logical, res, cout, ovf, sh_c, old_v);

  always_comb begin
    // R5
    v_keep_chk: assert (!logical || (nzcv[0] == old_v && nzcv[1] == sh_c));
    // R4
    zero_flag_chk: assert ((res == '0) == nzcv[2]);
  end

endmodule

// File: rtl/psr_saved_bank.sv
module psr_saved_bank
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [MODE_W-1:0] wmode,
  input  psr_t              wdata,
  input  logic [MODE_W-1:0] rmode,
  output psr_t              rdata
);

  psr_t                 slots [NUM_SAVED];
  logic [NUM_SAVED-1:0] wr_hit;
  logic [NUM_SAVED-1:0] rd_hit;
  logic [IDX_W-1:0]     wr_idx;

  genvar g;
  generate
    for (g = 0; g < NUM_SAVED; g++) begin : g_slot
      assign wr_hit[g] = we && (wmode == slot_mode(g));
      assign rd_hit[g] = (rmode == slot_mode(g));
    end
  endgenerate

  assign wr_idx = slot_idx(wmode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SAVED; k++) slots[k] <= SAVED_RESET;
    end else begin
      for (int k = 0; k < NUM_SAVED; k++) begin
        if (wr_hit[k]) begin
          slots[k]      <= wdata;
          slots[k].rsvd <= '0;
          if (!mode_valid(wdata.mode)) slots[k].mode <= slots[k].mode;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_SAVED; k++)
      if (rd_hit[k]) rdata = slots[k];
  end

  // R11
  slot_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && has_slot(wmode)) |=>
      (slots[$past(wr_idx)][31:28] == $past(wdata[31:28]) &&
       slots[$past(wr_idx)][7:5]   == $past(wdata[7:5])));

endmodule

// File: rtl/psr_bank.sv
module psr_bank
  import psr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_flags,
  input  logic        alu_logic,
  input  logic [31:0] alu_res,
  input  logic        alu_cout,
  input  logic        alu_ovf,
  input  logic        shift_cout,
  input  logic        exc_req,
  input  logic [2:0]  exc_kind,
  input  logic        exc_ret,
  input  logic        wr_en,
  input  logic        wr_saved,
  input  logic [31:0] wr_data,
  input  logic        rd_saved,
  output logic [31:0] rd_data,
  output logic [31:0] psr_out
);

  psr_t psr_q, psr_d, saved_cur, wr_psr, bank_wdata;
  logic [3:0]        alu_nzcv;
  logic [MODE_W-1:0] exc_target, bank_wmode;
  logic priv, owns_saved;
  logic exc_take, ret_take, cwr_take, swr_take, flag_take, bank_we;

  assign wr_psr     = psr_t'(wr_data);
  assign priv       = (psr_q.mode != MODE_USR);
  assign owns_saved = has_slot(psr_q.mode);
  assign exc_target = kind_mode(exc_kind);

  // Named events, highest priority first.
  assign exc_take  = exc_req && kind_valid(exc_kind);
  assign ret_take  = exc_ret && owns_saved && !exc_take;
  assign cwr_take  = wr_en && !wr_saved && !exc_take && !ret_take;
  assign swr_take  = wr_en && wr_saved && owns_saved && !exc_take && !ret_take;
  assign flag_take = set_flags && !exc_take && !ret_take && !cwr_take;

  psr_flag_unit u_flags (
    .logical (alu_logic),
    .res     (alu_res),
    .cout    (alu_cout),
    .ovf     (alu_ovf),
    .sh_c    (shift_cout),
    .old_v   (psr_q.v),
    .nzcv    (alu_nzcv)
  );

  assign bank_we    = exc_take || swr_take;
  assign bank_wmode = exc_take ? exc_target : psr_q.mode;
  assign bank_wdata = exc_take ? psr_q : wr_psr;

  psr_saved_bank u_saved (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bank_we),
    .wmode (bank_wmode),
    .wdata (bank_wdata),
    .rmode (psr_q.mode),
    .rdata (saved_cur)
  );

  always_comb begin
    psr_d = psr_q;
    if (exc_take) begin
      psr_d.i    = 1'b1;
      if (kind_masks_fast(exc_kind)) psr_d.f = 1'b1;
      psr_d.t    = 1'b0;
      psr_d.mode = exc_target;
    end else if (ret_take) begin
      psr_d = saved_cur;
    end else if (cwr_take) begin
      {psr_d.n, psr_d.z, psr_d.c, psr_d.v} = {wr_psr.n, wr_psr.z, wr_psr.c, wr_psr.v};
      if (priv) begin
        psr_d.i = wr_psr.i;
        psr_d.f = wr_psr.f;
        if (mode_valid(wr_psr.mode)) psr_d.mode = wr_psr.mode;
      end
    end else if (flag_take) begin
      {psr_d.n, psr_d.z, psr_d.c, psr_d.v} = alu_nzcv;
    end
    psr_d.rsvd = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) psr_q <= PSR_RESET;
    else        psr_q <= psr_d;
  end

  assign psr_out = psr_q;
  assign rd_data = rd_saved ? saved_cur : psr_q;

  // R6
  exc_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (psr_q.mode == $past(exc_target) && psr_q.i && !psr_q.t &&
                  psr_q[31:28] == $past(psr_q[31:28])));
  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags && !exc_req && !exc_ret && !wr_en) |=> $stable(psr_q[31:28]));
  // R7
  ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_take |=> (psr_q == $past(saved_cur)));
  // R9
  user_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_take && !priv) |=> $stable(psr_q[7:0]));
  // R8
  unpriv_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !owns_saved |-> (saved_cur == '0));
  // R12
  exc_over_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && set_flags) |=> (psr_q[31:28] == $past(psr_q[31:28])));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_q.rsvd == '0 && mode_valid(psr_q.mode)));

endmodule

// File: tb/psr_bank_test.sv
module psr_bank_test;

  localparam int CLK_P = 10;
  localparam int NVEC  = 7;

  // {logical, result, cout, ovf, shift carry, expected NZCV}
  localparam logic [39:0] VEC [NVEC] = '{
    {1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 4'b0110},
    {1'b0, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 4'b1001},
    {1'b1, 32'h0000_0005, 1'b0, 1'b0, 1'b1, 4'b0011},
    {1'b1, 32'hFFFF_0000, 1'b0, 1'b0, 1'b0, 4'b1001},
    {1'b0, 32'h7FFF_FFFF, 1'b1, 1'b1, 1'b0, 4'b0011},
    {1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 4'b0101},
    {1'b0, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'b0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        set_flags = 1'b0, alu_logic = 1'b0, alu_cout = 1'b0;
  logic        alu_ovf = 1'b0, shift_cout = 1'b0;
  logic [31:0] alu_res = '0;
  logic        exc_req = 1'b0, exc_ret = 1'b0;
  logic [2:0]  exc_kind = '0;
  logic        wr_en = 1'b0, wr_saved = 1'b0, rd_saved = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, psr_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  psr_bank uut (
    .clk(clk), .rst_n(rst_n), .set_flags(set_flags), .alu_logic(alu_logic),
    .alu_res(alu_res), .alu_cout(alu_cout), .alu_ovf(alu_ovf),
    .shift_cout(shift_cout), .exc_req(exc_req), .exc_kind(exc_kind),
    .exc_ret(exc_ret), .wr_en(wr_en), .wr_saved(wr_saved), .wr_data(wr_data),
    .rd_saved(rd_saved), .rd_data(rd_data), .psr_out(psr_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    set_flags = 1'b0; alu_logic = 1'b0; alu_res = '0; alu_cout = 1'b0;
    alu_ovf = 1'b0; shift_cout = 1'b0; exc_req = 1'b0; exc_kind = '0;
    exc_ret = 1'b0; wr_en = 1'b0; wr_saved = 1'b0; wr_data = '0;
  endtask

  // Inputs were set at a falling edge; cross one rising edge, clear, settle.
  task automatic step();
    @(negedge clk);
    idle();
    #1;
  endtask

  task automatic saved_read(input string req, input logic [31:0] exp);
    rd_saved = 1'b1; #1;
    chk(req, rd_data, exp);
    rd_saved = 1'b0; #1;
  endtask

  task automatic cwrite(input logic [31:0] d);
    wr_en = 1'b1; wr_saved = 1'b0; wr_data = d; step();
  endtask

  task automatic swrite(input logic [31:0] d);
    wr_en = 1'b1; wr_saved = 1'b1; wr_data = d; step();
  endtask

  task automatic take(input logic [2:0] k);
    exc_req = 1'b1; exc_kind = k; step();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;

    // R1 reset state
    chk("R1 live word", psr_out, 32'h0000_00D3);
    saved_read("R1 saved copy", 32'h0000_0010);

    // R4 R5 vector walk in supervisor mode
    for (int v = 0; v < NVEC; v++) begin
      set_flags  = 1'b1;
      alu_logic  = VEC[v][39];
      alu_res    = VEC[v][38:7];
      alu_cout   = VEC[v][6];
      alu_ovf    = VEC[v][5];
      shift_cout = VEC[v][4];
      step();
      chk(VEC[v][39] ? "R5 logical flags" : "R4 arithmetic flags",
          {28'h0, psr_out[31:28]}, {28'h0, VEC[v][3:0]});
    end

    // R3 flags hold without set_flags
    alu_res = '0; alu_cout = 1'b1; alu_ovf = 1'b1; step();
    chk("R3 hold", psr_out, 32'h0000_00D3);

    // R10 privileged write enters user mode
    cwrite(32'hA000_0010);
    chk("R10 priv write", psr_out, 32'hA000_0010);

    // R9 user write changes flags only
    cwrite(32'h5000_00D3);
    chk("R9 user write", psr_out, 32'h5000_0010);

    // R8 user mode: no saved copy, write ignored, return ignored
    saved_read("R8 user read", 32'h0);
    swrite(32'hF000_00D3);
    saved_read("R8 user write", 32'h0);
    exc_ret = 1'b1; step();
    chk("R8 user return", psr_out, 32'h5000_0010);

    // R6 interrupt entry from user
    take(3'd4);
    chk("R6 irq entry", psr_out, 32'h5000_0092);
    saved_read("R6 irq save", 32'h5000_0010);

    // R12 fast interrupt entry with a concurrent flag update
    exc_req = 1'b1; exc_kind = 3'd5; set_flags = 1'b1; alu_cout = 1'b1; step();
    chk("R12 fiq over flags", psr_out, 32'h5000_00D1);
    saved_read("R6 fiq save", 32'h5000_0092);

    // R7 R12 return with a concurrent flag update
    exc_ret = 1'b1; set_flags = 1'b1; alu_cout = 1'b1; step();
    chk("R7 return to irq", psr_out, 32'h5000_0092);
    exc_ret = 1'b1; step();
    chk("R7 return to user", psr_out, 32'h5000_0010);

    // R6 undefined entry keeps F
    take(3'd1);
    chk("R6 und entry", psr_out, 32'h5000_009B);

    // R11 saved write drops reserved bits, then R7 restores T
    swrite(32'h2FFF_FF30);
    saved_read("R11 saved write", 32'h2000_0030);
    exc_ret = 1'b1; step();
    chk("R7 restore T", psr_out, 32'h2000_0030);

    // R6 supervisor entry clears T
    take(3'd2);
    chk("R6 svc entry", psr_out, 32'h2000_0093);
    saved_read("R6 svc save", 32'h2000_0030);

    // R6 reset-kind entry sets F
    take(3'd0);
    chk("R6 reset entry", psr_out, 32'h2000_00D3);
    saved_read("R6 reset save", 32'h2000_0093);

    // R6 invalid kind ignored
    take(3'd6);
    chk("R6 kind 6", psr_out, 32'h2000_00D3);
    saved_read("R6 kind 6 saved", 32'h2000_0093);

    // R10 invalid mode code keeps mode
    cwrite(32'h0000_0005);
    chk("R10 invalid mode", psr_out, 32'h0000_0013);

    // R11 invalid mode in saved write keeps stored mode
    swrite(32'h8000_000C);
    saved_read("R11 invalid mode", 32'h8000_0013);

    // R12 saved write dropped under a return
    exc_ret = 1'b1; wr_en = 1'b1; wr_saved = 1'b1; wr_data = 32'h4000_0013; step();
    chk("R12 return wins", psr_out, 32'h8000_0013);
    saved_read("R12 write dropped", 32'h8000_0013);

    // R8 system mode
    cwrite(32'h0000_00DF);
    chk("R10 enter system", psr_out, 32'h0000_00DF);
    saved_read("R8 system read", 32'h0);
    exc_ret = 1'b1; step();
    chk("R8 system return", psr_out, 32'h0000_00DF);

    // R12 live write beats flag update
    wr_en = 1'b1; wr_data = 32'h8000_00DF; set_flags = 1'b1; alu_cout = 1'b1; step();
    chk("R12 write over flags", psr_out, 32'h8000_00DF);

    // R10 T not writable directly
    cwrite(32'h0000_00FF);
    chk("R10 T kept", psr_out, 32'h0000_00DF);

    // R2 direct read of the live word
    #1 chk("R2 live read", rd_data, 32'h0000_00DF);

    finish_run();
  end

endmodule